// File: doc/BRIEF.md
# Descriptor Completion Condition Evaluator

This block settles what a descriptor-driven DMA channel does when one descriptor step completes. Three independent decisions are made from one step: whether the step must hold in a wait, whether the channel interrupt is raised, and whether the command pointer follows the descriptor's dependency word (a branch) or moves on to the next sequential descriptor. Each decision has its own two-bit mode taken from the command word and its own select register. A select register pairs a four-bit mask with a four-bit compare value, and both are applied to the low bits of the device-status field.

A channel sequencer presents the command mode bits, the three select registers, the current status, the current pointer and the dependency word, then pulses `step_i` for one cycle. One cycle later the block presents the new pointer with a one-cycle update strobe, the sticky branch-taken flag and the wait flag. The interrupt line is a level. It stays high until an acknowledge input clears it. Descriptor fetch and data movement belong to the surrounding channel logic.

Top module: `desc_cond_eval`

## Requirements
- R1: After reset, `irq_o`, `wait_o`, `bt_o`, `ptr_upd_o` and `ptr_o` are all zero.
- R2: For each select register, the mask is bits 19:16 and the compare value is bits 3:0. The condition is true when the low four status bits ANDed with the mask equal the compare value ANDed with the mask. All other select bits and status bits 7:4 have no effect.
- R3: `mode_i` bits 5:4 hold the interrupt mode, bits 3:2 the branch mode and bits 1:0 the wait mode. In each field, code 0 means never, 1 means act when the condition is true, 2 means act when the condition is false, and 3 means always.
- R4: When a step's wait decision holds, `wait_o` is 1 from the next cycle. In that case there is no pointer update, the interrupt is not raised, and `bt_o` keeps its value.
- R5: A step whose wait decision does not hold drives `wait_o` to 0 and pulses `ptr_upd_o` for exactly the cycle after the step.
- R6: When the branch is taken, `ptr_o` becomes the dependency word and `bt_o` becomes 1.
- R7: When the branch is not taken, `ptr_o` becomes the current pointer plus 16 and `bt_o` becomes 0.
- R8: `irq_o` rises in the cycle after a non-waiting step whose interrupt decision holds. It then stays high until a cycle with `irq_ack_i` high, after which it clears. A new raise in the same cycle as an acknowledge wins.
- R9: Without a step, `ptr_o` and `bt_o` hold, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One-cycle strobe: a descriptor step completes |
| mode_i | input | 6 | Interrupt, branch and wait mode fields |
| irq_sel_i | input | SEL_W | Interrupt select register |
| br_sel_i | input | SEL_W | Branch select register |
| wait_sel_i | input | SEL_W | Wait select register |
| status_i | input | STAT_W | Device-status field |
| cur_ptr_i | input | PTR_W | Current command pointer |
| dep_i | input | PTR_W | Descriptor dependency word (branch target) |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt level |
| wait_o | output | 1 | Last step held in a wait |
| bt_o | output | 1 | Sticky branch-taken flag |
| ptr_upd_o | output | 1 | New pointer valid strobe |
| ptr_o | output | PTR_W | Next command pointer |

## Verification
All results of a step are registered exactly once. The pointer, the update strobe, the branch-taken flag, the wait flag and a new interrupt therefore all appear one clock after the edge that samples `step_i`. An acknowledge clears the interrupt one clock after its sampling edge. The bench drives each step on a falling edge and drops it on the next falling edge. It compares every output at that second falling edge, which lies half a period after the registering edge and inside the single cycle in which the update strobe is high. Hold checks then look again several falling edges later, with no step applied.

// File: rtl/cdbw_pkg.sv
package cdbw_pkg;

   typedef enum logic [1:0] {
      MODE_NEVER    = 2'd0,
      MODE_IF_TRUE  = 2'd1,
      MODE_IF_FALSE = 2'd2,
      MODE_ALWAYS   = 2'd3
   } act_mode_e;

   localparam int MODE_W   = 2;
   localparam int PURP_WT  = 0;
   localparam int PURP_BR  = 1;
   localparam int PURP_IRQ = 2;
   localparam int NUM_PURP = 3;
   localparam int MODES_W  = NUM_PURP * MODE_W;

endpackage

// File: rtl/dce_sel_match.sv
module dce_sel_match
   import cdbw_pkg::*;
#(
   parameter int CMP_W = 4
) (
   input  logic [CMP_W-1:0] mask_i,
   input  logic [CMP_W-1:0] val_i,
   input  logic [CMP_W-1:0] stat_i,
   input  act_mode_e        mode_i,
   output logic             act_o
);

   logic cond;

   assign cond = ((stat_i ^ val_i) & mask_i) == '0;

   always_comb begin
      unique case (mode_i)
         MODE_NEVER:    act_o = 1'b0;
         MODE_IF_TRUE:  act_o = cond;
         MODE_IF_FALSE: act_o = !cond;
         default:       act_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/dce_step_reg.sv
module dce_step_reg #(
   parameter int PTR_W      = 32,
   parameter int STEP_BYTES = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             do_wait_i,
   input  logic             do_irq_i,
   input  logic             do_br_i,
   input  logic [PTR_W-1:0] cur_ptr_i,
   input  logic [PTR_W-1:0] dep_i,
   input  logic             irq_ack_i,
   output logic             irq_o,
   output logic             wait_o,
   output logic             bt_o,
   output logic             ptr_upd_o,
   output logic [PTR_W-1:0] ptr_o
);

   localparam logic [PTR_W-1:0] STEP_INC = PTR_W'(STEP_BYTES);

   logic proceed;

   assign proceed = step_i && !do_wait_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         irq_o     <= 1'b0;
         wait_o    <= 1'b0;
         bt_o      <= 1'b0;
         ptr_upd_o <= 1'b0;
         ptr_o     <= '0;
      end else begin
         ptr_upd_o <= proceed;
         if (step_i) begin
            wait_o <= do_wait_i;
         end
         if (proceed) begin
            bt_o  <= do_br_i;
            ptr_o <= do_br_i ? dep_i : cur_ptr_i + STEP_INC;
         end
         if (proceed && do_irq_i) begin
            irq_o <= 1'b1;
         end else if (irq_ack_i) begin
            irq_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/desc_cond_eval.sv
module desc_cond_eval
   import cdbw_pkg::*;
#(
   parameter int PTR_W      = 32,
   parameter int SEL_W      = 32,
   parameter int STAT_W     = 8,
   parameter int CMP_W      = 4,
   parameter int MASK_LSB   = 16,
   parameter int STEP_BYTES = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               step_i,
   input  logic [MODES_W-1:0] mode_i,
   input  logic [SEL_W-1:0]   irq_sel_i,
   input  logic [SEL_W-1:0]   br_sel_i,
   input  logic [SEL_W-1:0]   wait_sel_i,
   input  logic [STAT_W-1:0]  status_i,
   input  logic [PTR_W-1:0]   cur_ptr_i,
   input  logic [PTR_W-1:0]   dep_i,
   input  logic               irq_ack_i,
   output logic               irq_o,
   output logic               wait_o,
   output logic               bt_o,
   output logic               ptr_upd_o,
   output logic [PTR_W-1:0]   ptr_o
);

   if (CMP_W > STAT_W) begin : g_bad_stat
      $error("CMP_W must not exceed STAT_W");
   end
   if (MASK_LSB < CMP_W || MASK_LSB + CMP_W > SEL_W) begin : g_bad_sel
      $error("mask field must sit above the value field inside SEL_W");
   end
   if (STEP_BYTES <= 0 || STEP_BYTES % 4 != 0) begin : g_bad_step
      $error("STEP_BYTES must be a positive multiple of 4");
   end

   logic [NUM_PURP-1:0][SEL_W-1:0] sel_arr;
   logic [NUM_PURP-1:0]            act;
   logic                           unused_bits;

   assign sel_arr[PURP_WT]  = wait_sel_i;
   assign sel_arr[PURP_BR]  = br_sel_i;
   assign sel_arr[PURP_IRQ] = irq_sel_i;
   assign unused_bits = ^{irq_sel_i, br_sel_i, wait_sel_i, status_i};

   for (genvar g = 0; g < NUM_PURP; g++) begin : g_purp
      dce_sel_match #(.CMP_W(CMP_W)) u_match (
         .mask_i (sel_arr[g][MASK_LSB +: CMP_W]),
         .val_i  (sel_arr[g][CMP_W-1:0]),
         .stat_i (status_i[CMP_W-1:0]),
         .mode_i (act_mode_e'(mode_i[g*MODE_W +: MODE_W])),
         .act_o  (act[g])
      );
   end

   dce_step_reg #(.PTR_W(PTR_W), .STEP_BYTES(STEP_BYTES)) u_step (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step_i),
      .do_wait_i (act[PURP_WT]),
      .do_irq_i  (act[PURP_IRQ]),
      .do_br_i   (act[PURP_BR]),
      .cur_ptr_i (cur_ptr_i),
      .dep_i     (dep_i),
      .irq_ack_i (irq_ack_i),
      .irq_o     (irq_o),
      .wait_o    (wait_o),
      .bt_o      (bt_o),
      .ptr_upd_o (ptr_upd_o),
      .ptr_o     (ptr_o)
   );

endmodule

// File: rtl/dce_chk.sv
module dce_chk #(
   parameter int PTR_W      = 32,
   parameter int STEP_BYTES = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             step_i,
   input logic [PTR_W-1:0] cur_ptr_i,
   input logic [PTR_W-1:0] dep_i,
   input logic             irq_ack_i,
   input logic             irq_o,
   input logic             wait_o,
   input logic             bt_o,
   input logic             ptr_upd_o,
   input logic [PTR_W-1:0] ptr_o
);

   localparam logic [PTR_W-1:0] STEP_INC = PTR_W'(STEP_BYTES);

   // R4
   upd_excl_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_upd_o |-> !wait_o);

   // R5
   upd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_upd_o |-> $past(step_i));

   // R6
   br_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ptr_upd_o && bt_o) |-> ptr_o == $past(dep_i));

   // R7
   seq_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ptr_upd_o && !bt_o) |-> ptr_o == $past(cur_ptr_i) + STEP_INC);

   // R8
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(step_i));

   // R8
   irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_ack_i && !step_i) |=> !irq_o);

   // R9
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> ($stable(bt_o) && $stable(ptr_o)));

endmodule

bind desc_cond_eval dce_chk #(.PTR_W(PTR_W), .STEP_BYTES(STEP_BYTES)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .step_i    (step_i),
   .cur_ptr_i (cur_ptr_i),
   .dep_i     (dep_i),
   .irq_ack_i (irq_ack_i),
   .irq_o     (irq_o),
   .wait_o    (wait_o),
   .bt_o      (bt_o),
   .ptr_upd_o (ptr_upd_o),
   .ptr_o     (ptr_o)
);

// File: tb/desc_cond_eval_tb.sv
`timescale 1ns/1ps
module desc_cond_eval_tb;

   typedef struct packed {
      logic [5:0] md;
      logic [3:0] im, iv, bm, bv, wm, wv;
      logic [7:0] st;
      logic       e_irq, e_wait, e_bt, e_br;
   } vec_t;

   localparam int NV = 10;
   localparam logic [31:0] JUNK = 32'hA000_FFF0;
   localparam vec_t VECS [NV] = '{
      '{6'h30, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
      '{6'h0C, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
      '{6'h14, 4'hF, 4'h5, 4'h1, 4'h0, 4'h0, 4'h0, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0},
      '{6'h28, 4'h3, 4'h1, 4'h4, 4'h0, 4'h0, 4'h0, 8'h05, 1'b0, 1'b0, 1'b1, 1'b1},
      '{6'h33, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
      '{6'h31, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2, 4'h2, 8'h02, 1'b0, 1'b1, 1'b1, 1'b0},
      '{6'h12, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2, 4'h2, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0},
      '{6'h14, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 8'hF0, 1'b1, 1'b0, 1'b1, 1'b1},
      '{6'h29, 4'h8, 4'h8, 4'h8, 4'h0, 4'h8, 4'h0, 8'h08, 1'b0, 1'b0, 1'b1, 1'b1},
      '{6'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        step_i = 1'b0;
   logic [5:0]  mode_i = '0;
   logic [31:0] irq_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
   logic [7:0]  status_i = '0;
   logic [31:0] cur_ptr_i = '0, dep_i = '0;
   logic        irq_ack_i = 1'b0;
   logic        irq_o, wait_o, bt_o, ptr_upd_o;
   logic [31:0] ptr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk_i = ~clk_i;

   desc_cond_eval u_dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .mode_i(mode_i),
      .irq_sel_i(irq_sel_i), .br_sel_i(br_sel_i), .wait_sel_i(wait_sel_i),
      .status_i(status_i), .cur_ptr_i(cur_ptr_i), .dep_i(dep_i),
      .irq_ack_i(irq_ack_i), .irq_o(irq_o), .wait_o(wait_o), .bt_o(bt_o),
      .ptr_upd_o(ptr_upd_o), .ptr_o(ptr_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_step(input logic [5:0] md);
      @(negedge clk_i);
      mode_i = md;
      step_i = 1'b1;
      @(negedge clk_i);
      step_i = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk_i);
      irq_ack_i = 1'b1;
      @(negedge clk_i);
      irq_ack_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_ptr;
      logic [31:0] held_ptr;
      logic        held_bt;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R1 reset state
      chk(irq_o == 1'b0, "R1 irq", 32'(irq_o), 32'd0);
      chk(wait_o == 1'b0, "R1 wait", 32'(wait_o), 32'd0);
      chk(bt_o == 1'b0, "R1 bt", 32'(bt_o), 32'd0);
      chk(ptr_upd_o == 1'b0, "R1 upd", 32'(ptr_upd_o), 32'd0);
      chk(ptr_o == 32'd0, "R1 ptr", ptr_o, 32'd0);

      // table walk: R2 select decode, R3 modes, R4..R7 outcomes
      for (int i = 0; i < NV; i++) begin
         irq_sel_i  = JUNK | {12'd0, VECS[i].im, 12'd0, VECS[i].iv};
         br_sel_i   = JUNK | {12'd0, VECS[i].bm, 12'd0, VECS[i].bv};
         wait_sel_i = JUNK | {12'd0, VECS[i].wm, 12'd0, VECS[i].wv};
         status_i   = VECS[i].st;
         cur_ptr_i  = 32'h0000_1000 + 32'(i) * 32'h100;
         dep_i      = 32'h0004_0000 + 32'(i) * 32'h40;
         exp_ptr    = VECS[i].e_br ? dep_i : cur_ptr_i + 32'd16;
         do_step(VECS[i].md);
         chk(irq_o == VECS[i].e_irq, $sformatf("R2/R3/R8 irq vec %0d", i), 32'(irq_o), 32'(VECS[i].e_irq));
         chk(wait_o == VECS[i].e_wait, $sformatf("R3/R4 wait vec %0d", i), 32'(wait_o), 32'(VECS[i].e_wait));
         chk(bt_o == VECS[i].e_bt, $sformatf("R4/R6/R7 bt vec %0d", i), 32'(bt_o), 32'(VECS[i].e_bt));
         chk(ptr_upd_o == !VECS[i].e_wait, $sformatf("R4/R5 upd vec %0d", i), 32'(ptr_upd_o), 32'(!VECS[i].e_wait));
         if (!VECS[i].e_wait)
            chk(ptr_o == exp_ptr, $sformatf("R6/R7 ptr vec %0d", i), ptr_o, exp_ptr);
         @(negedge clk_i);
         chk(ptr_upd_o == 1'b0, $sformatf("R5 strobe one cycle vec %0d", i), 32'(ptr_upd_o), 32'd0);
         ack_pulse();
      end

      // R8 level holds without acknowledge
      irq_sel_i = '0; br_sel_i = '0; wait_sel_i = '0; status_i = '0;
      do_step(6'h30);
      repeat (5) @(negedge clk_i);
      chk(irq_o == 1'b1, "R8 irq held", 32'(irq_o), 32'd1);
      // R8 raise wins over simultaneous acknowledge
      @(negedge clk_i);
      irq_ack_i = 1'b1;
      mode_i = 6'h30;
      step_i = 1'b1;
      @(negedge clk_i);
      step_i = 1'b0;
      irq_ack_i = 1'b0;
      chk(irq_o == 1'b1, "R8 set beats ack", 32'(irq_o), 32'd1);
      ack_pulse();
      chk(irq_o == 1'b0, "R8 ack clears", 32'(irq_o), 32'd0);

      // R9 no step: pointer and flag hold
      cur_ptr_i = 32'h0000_2000;
      dep_i = 32'h0008_0000;
      do_step(6'h0C);
      held_ptr = ptr_o;
      held_bt = bt_o;
      chk(held_ptr == 32'h0008_0000, "R6 branch target", held_ptr, 32'h0008_0000);
      mode_i = 6'h30;
      cur_ptr_i = 32'h1234_5670;
      dep_i = 32'h7654_3210;
      status_i = 8'hFF;
      repeat (4) @(negedge clk_i);
      chk(ptr_o == held_ptr, "R9 ptr hold", ptr_o, held_ptr);
      chk(bt_o == held_bt, "R9 bt hold", 32'(bt_o), 32'(held_bt));
      chk(irq_o == 1'b0, "R9 no irq without step", 32'(irq_o), 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule